// File: doc/BRIEF.md
# Blank-Origin Video Timing Generator

This block produces the horizontal and vertical timing of a raster display from a set of configuration inputs. Both of its counters start at zero on the first blanked pixel of a line or the first blanked line of a frame, not on the first visible one. As a result, the blank-end, sync-start and sync-end values are all offsets into the blanking interval. The two total values hold the number of positions minus one, and each counter wraps after it reaches its total.

The block drives horizontal and vertical sync, a blank flag and its complement, an active-video flag, and both counters. Each sync output is active low unless its polarity bit inverts it. A double-pixel mode holds each horizontal count for two clocks. Software then programs every horizontal value at half its pixel-domain size, and the line keeps the same length in clocks.

The configuration is sampled while reset is held and again only when both counters wrap together. A frame therefore never mixes old and new settings.

Top module: `bot_timing_gen`

## Requirements
- R1: When double-pixel mode is off, `h_count` steps by one on every clock. After it reaches `h_total` it returns to 0 on the next clock.
- R2: `v_count` steps by one only on the clock where `h_count` wraps. After it reaches `v_total` it returns to 0 on its next step.
- R3: `active` is 1 exactly when `h_count >= h_blank_end` and `v_count >= v_blank_end`. `blank` is always the inverse of `active`.
- R4: Horizontal sync is asserted exactly when `h_sync_start < h_count < h_sync_end`, so the start value is the front porch minus one.
- R5: Vertical sync is asserted exactly when `v_sync_start <= v_count < v_sync_end`.
- R6: Both sync outputs are driven low when asserted and high otherwise. Bit 0 of `sync_pol` inverts `hsync` and bit 3 inverts `vsync`. Bits 1 and 2 have no effect.
- R7: When `dbl_pixel` is 1, every horizontal count value lasts exactly two clocks, and the vertical behaviour still follows R2.
- R8: All configuration inputs, including polarity and double-pixel mode, are captured while reset is held and on the clock where both counters wrap together. Changes at any other time have no effect until that point.
- R9: Reset is synchronous and active low. While it is held, both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_total | input | 12 | Positions per line minus one |
| h_sync_start | input | 12 | Offset of the last position before hsync |
| h_sync_end | input | 12 | Offset of the first position after hsync |
| h_blank_end | input | 12 | First visible position in a line |
| v_total | input | 12 | Lines per frame minus one |
| v_sync_start | input | 12 | First vsync line |
| v_sync_end | input | 12 | First line after vsync |
| v_blank_end | input | 12 | First visible line |
| sync_pol | input | 4 | Bit 0 inverts hsync, bit 3 inverts vsync |
| dbl_pixel | input | 1 | Hold each horizontal count for two clocks |
| hsync | output | 1 | Horizontal sync, polarity per `sync_pol` |
| vsync | output | 1 | Vertical sync, polarity per `sync_pol` |
| blank | output | 1 | High outside the visible area |
| active | output | 1 | High inside the visible area |
| h_count | output | 12 | Horizontal position from start of blanking |
| v_count | output | 12 | Vertical line from start of blanking |

## Verification
The bench drives four configurations and compares every clock against a model of its own. The first uses narrow syncs with the unused polarity bits set, which shows whether the exclusive horizontal and inclusive vertical sync windows are placed correctly. The second uses both inversions and a vsync that starts on line 0. The third runs in double-pixel mode with a vsync that runs up to the last line, which separates a held count from a stepping one. The fourth has no blanking and an empty hsync window, which exposes off-by-one comparisons at zero. Directed runs change the configuration part-way through a frame, including a switch into double-pixel mode, and apply reset mid-frame. These runs show whether new settings wait for the frame wrap.

// File: rtl/bot_pkg.sv
// Shared types for the blank-origin timing generator.
// Assumes both axes use the same counter width.
package bot_pkg;
    localparam int CNT_W     = 12;
    localparam int POL_W     = 4;
    localparam int POL_H_BIT = 0;
    localparam int POL_V_BIT = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    // Timing settings of one axis, all measured from the start of blanking.
    typedef struct packed {
        cnt_t total;
        cnt_t sync_start;
        cnt_t sync_end;
        cnt_t blank_end;
    } axis_cfg_t;
endpackage

// File: rtl/bot_cfg_shadow.sv
// Holds the settings in force for the current frame.
// Assumes load pulses for one clock when both counters wrap together.
// While reset is held it follows its inputs continuously.
module bot_cfg_shadow
    import bot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  axis_cfg_t h_in,
    input  axis_cfg_t v_in,
    input  logic      pol_h_in,
    input  logic      pol_v_in,
    input  logic      dbl_in,
    output axis_cfg_t h_cfg,
    output axis_cfg_t v_cfg,
    output logic      pol_h,
    output logic      pol_v,
    output logic      dbl
);
    // Capture new settings during reset or on the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            h_cfg <= h_in;
            v_cfg <= v_in;
            pol_h <= pol_h_in;
            pol_v <= pol_v_in;
            dbl   <= dbl_in;
        end
    end
endmodule

// File: rtl/bot_axis_counter.sv
// Position counter for one axis: counts 0..limit, steps when step is high.
// Assumes limit does not change while the counter is mid-sweep.
module bot_axis_counter
    import bot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  cnt_t limit,
    output cnt_t count,
    output logic wrap
);
    logic at_limit;

    // Detect the last position of the sweep.
    always_comb at_limit = (count == limit);

    // Report a wrap on the step that leaves the last position.
    always_comb wrap = step && at_limit;

    // Advance the position, or return to zero after the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (step) begin
            count <= at_limit ? '0 : count + cnt_t'(1);
        end
    end
endmodule

// File: rtl/bot_axis_decode.sv
// Turns one axis position into a sync window and a visible flag.
// START_EXCL picks whether sync begins after sync_start (1) or on it (0).
// Assumes the offsets are already the ones in force for this frame.
module bot_axis_decode
    import bot_pkg::*;
#(
    parameter bit START_EXCL = 1'b0
) (
    input  cnt_t count,
    input  cnt_t sync_start,
    input  cnt_t sync_end,
    input  cnt_t blank_end,
    output logic sync_act,
    output logic visible
);
    logic past_start;

    generate
        if (START_EXCL) begin : g_excl
            // Sync opens on the position after the start value.
            always_comb past_start = (count > sync_start);
        end else begin : g_incl
            // Sync opens on the start value itself.
            always_comb past_start = (count >= sync_start);
        end
    endgenerate

    // Sync window closes on the end value.
    always_comb sync_act = past_start && (count < sync_end);

    // Visible once blanking for this axis is over.
    always_comb visible = (count >= blank_end);
endmodule

// File: rtl/bot_timing_gen.sv
// Blank-origin raster timing generator.
// Counters start at the first blanked position, and totals are stored minus one.
// Settings apply from reset or from the next frame boundary.
// Double-pixel mode holds each horizontal count for two clocks.
module bot_timing_gen
    import bot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] h_sync_start,
    input  logic [CNT_W-1:0] h_sync_end,
    input  logic [CNT_W-1:0] h_blank_end,
    input  logic [CNT_W-1:0] v_total,
    input  logic [CNT_W-1:0] v_sync_start,
    input  logic [CNT_W-1:0] v_sync_end,
    input  logic [CNT_W-1:0] v_blank_end,
    input  logic [POL_W-1:0] sync_pol,
    input  logic             dbl_pixel,
    output logic             hsync,
    output logic             vsync,
    output logic             blank,
    output logic             active,
    output logic [CNT_W-1:0] h_count,
    output logic [CNT_W-1:0] v_count
);
    axis_cfg_t h_in, v_in, sh_h, sh_v;
    logic      sh_pol_h, sh_pol_v, sh_dbl;
    logic      phase, h_step, h_wrap, v_wrap;
    logic      h_sync_act, v_sync_act, h_vis, v_vis;
    logic      unused_pol;

    // Gather the configuration inputs into per-axis records.
    always_comb begin
        h_in = '{total: h_total, sync_start: h_sync_start,
                 sync_end: h_sync_end, blank_end: h_blank_end};
        v_in = '{total: v_total, sync_start: v_sync_start,
                 sync_end: v_sync_end, blank_end: v_blank_end};
    end

    // Polarity bits other than the two sync controls are not used.
    always_comb unused_pol = ^{sync_pol[2:1]};

    bot_cfg_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (v_wrap),
        .h_in     (h_in),
        .v_in     (v_in),
        .pol_h_in (sync_pol[POL_H_BIT]),
        .pol_v_in (sync_pol[POL_V_BIT]),
        .dbl_in   (dbl_pixel),
        .h_cfg    (sh_h),
        .v_cfg    (sh_v),
        .pol_h    (sh_pol_h),
        .pol_v    (sh_pol_v),
        .dbl      (sh_dbl)
    );

    // Alternate phase in double-pixel mode; hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else begin
            phase <= sh_dbl ? ~phase : 1'b0;
        end
    end

    // Horizontal count advances every clock, or every second clock.
    always_comb h_step = ~sh_dbl | phase;

    bot_axis_counter u_hcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (h_step),
        .limit (sh_h.total),
        .count (h_count),
        .wrap  (h_wrap)
    );

    bot_axis_counter u_vcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (h_wrap),
        .limit (sh_v.total),
        .count (v_count),
        .wrap  (v_wrap)
    );

    bot_axis_decode #(.START_EXCL(1'b1)) u_hdec (
        .count      (h_count),
        .sync_start (sh_h.sync_start),
        .sync_end   (sh_h.sync_end),
        .blank_end  (sh_h.blank_end),
        .sync_act   (h_sync_act),
        .visible    (h_vis)
    );

    bot_axis_decode #(.START_EXCL(1'b0)) u_vdec (
        .count      (v_count),
        .sync_start (sh_v.sync_start),
        .sync_end   (sh_v.sync_end),
        .blank_end  (sh_v.blank_end),
        .sync_act   (v_sync_act),
        .visible    (v_vis)
    );

    // Active-low sync by default; a set polarity bit flips it.
    always_comb begin
        hsync = ~h_sync_act ^ sh_pol_h;
        vsync = ~v_sync_act ^ sh_pol_v;
    end

    // Visible area needs both axes out of blanking.
    always_comb begin
        active = h_vis & v_vis;
        blank  = ~active;
    end
endmodule

// File: rtl/bot_timing_chk.sv
// Temporal checks for bot_timing_gen, attached with bind.
module bot_timing_chk
    import bot_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input cnt_t      h_count,
    input cnt_t      v_count,
    input logic      active,
    input logic      sh_dbl,
    input axis_cfg_t sh_h
);
    AST_H_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (h_count == $past(h_count) || h_count == $past(h_count) + cnt_t'(1) || h_count == '0)); // R1

    AST_V_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (h_count != '0) |-> $stable(v_count)); // R2

    AST_NO_ACTIVE_AT_H0: assert property (@(posedge clk) disable iff (!rst_n)
        (h_count == '0 && sh_h.blank_end != '0) |-> !active); // R3

    AST_DBL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_dbl && !$stable(h_count)) |=> $stable(h_count)); // R7

    AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (h_count != '0 || v_count != '0) |-> $stable(sh_h)); // R8

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (h_count == '0 && v_count == '0)); // R9
endmodule

bind bot_timing_gen bot_timing_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_count (h_count),
    .v_count (v_count),
    .active  (active),
    .sh_dbl  (sh_dbl),
    .sh_h    (sh_h)
);

// File: tb/test_bot_timing_gen.sv
module test_bot_timing_gen;
    import bot_pkg::*;

    typedef struct packed {
        cnt_t ht, hss, hse, hbe, vt, vss, vse, vbe;
        logic [3:0] pol;
        logic dbl;
    } tv_t;

    // Configuration vectors; expected outputs come from the model below.
    localparam tv_t VECS [4] = '{
        '{12'd9, 12'd0, 12'd2, 12'd3, 12'd5, 12'd1, 12'd2, 12'd2, 4'b0110, 1'b0},
        '{12'd7, 12'd1, 12'd4, 12'd4, 12'd4, 12'd0, 12'd2, 12'd1, 4'b1001, 1'b0},
        '{12'd5, 12'd0, 12'd2, 12'd2, 12'd3, 12'd1, 12'd3, 12'd1, 4'b0001, 1'b1},
        '{12'd3, 12'd0, 12'd1, 12'd0, 12'd2, 12'd0, 12'd1, 12'd0, 4'b1000, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    tv_t  drv = VECS[0];
    logic hsync, vsync, blank, active;
    cnt_t h_count, v_count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    tv_t cur;
    int  mh, mv;
    bit  mph;

    always #10 clk = ~clk;

    bot_timing_gen i_bot_timing_gen (
        .clk(clk), .rst_n(rst_n),
        .h_total(drv.ht), .h_sync_start(drv.hss), .h_sync_end(drv.hse), .h_blank_end(drv.hbe),
        .v_total(drv.vt), .v_sync_start(drv.vss), .v_sync_end(drv.vse), .v_blank_end(drv.vbe),
        .sync_pol(drv.pol), .dbl_pixel(drv.dbl),
        .hsync(hsync), .vsync(vsync), .blank(blank), .active(active),
        .h_count(h_count), .v_count(v_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare all outputs with the model state of this cycle.
    task automatic check_all();
        bit hs, vs, act;
        string ht;
        hs  = (mh > int'(cur.hss)) && (mh < int'(cur.hse));
        vs  = (mv >= int'(cur.vss)) && (mv < int'(cur.vse));
        act = (mh >= int'(cur.hbe)) && (mv >= int'(cur.vbe));
        ht  = (cur != drv) ? "R8 h_count" : (cur.dbl ? "R7 h_count" : "R1 h_count");
        chk(ht, int'(h_count), mh);
        chk("R2 v_count", int'(v_count), mv);
        chk("R3 active", int'(active), int'(act));
        chk("R3 blank", int'(blank), int'(!act));
        chk("R4 R6 hsync", int'(hsync), int'(hs ? cur.pol[0] : !cur.pol[0]));
        chk("R5 R6 vsync", int'(vsync), int'(vs ? cur.pol[3] : !cur.pol[3]));
    endtask

    // Advance the model by one clock, per R1, R2, R7 and R8.
    task automatic model_step();
        bit adv;
        adv = !cur.dbl || mph;
        mph = cur.dbl ? !mph : 1'b0;
        if (adv) begin
            if (mh == int'(cur.ht)) begin
                mh = 0;
                if (mv == int'(cur.vt)) begin
                    mv  = 0;
                    cur = drv;
                end else begin
                    mv++;
                end
            end else begin
                mh++;
            end
        end
    endtask

    task automatic run_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            check_all();
        end
    endtask

    // Hold reset, check the counters under reset (R9), then release.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 h_count in reset", int'(h_count), 0);
        chk("R9 v_count in reset", int'(v_count), 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur = drv;
        mh = 0;
        mv = 0;
        mph = 1'b0;
        check_all();
    endtask

    function automatic int frame_len(input tv_t t);
        return (int'(t.ht) + 1) * (int'(t.vt) + 1) * (t.dbl ? 2 : 1);
    endfunction

    initial begin
        // Table walk: every vector over two full frames.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            drv = VECS[i];
            do_reset();
            run_cycles(2 * frame_len(VECS[i]) + 3);
        end

        // R8: change settings mid-frame; old ones must last until the wrap.
        @(negedge clk);
        drv = VECS[0];
        do_reset();
        run_cycles(17);
        drv = VECS[1];
        run_cycles(frame_len(VECS[0]) + 2 * frame_len(VECS[1]));

        // R7 R8: switch into double-pixel mode mid-frame.
        drv = VECS[2];
        run_cycles(frame_len(VECS[1]) + 2 * frame_len(VECS[2]));

        // R9: reset in the middle of a frame.
        run_cycles(7);
        do_reset();
        run_cycles(frame_len(VECS[2]));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule